// File: doc/BRIEF.md
# Sub-word Write Merge Bridge

This bridge sits between a requester that issues configuration writes of one, two or four bytes and a 32-bit register file that only accepts full-word accesses. A four-byte write goes straight through. A narrower write becomes a read-modify-write: the bridge reads the aligned word, merges the new byte lanes into it and writes the whole word back.

Some registers hold status bits that are cleared by writing a one. If such a bit reads back as one and sits outside the lanes being written, a plain merge would write that one back and clear the bit by accident. Before the merge, the bridge therefore ANDs the read-back word with a keep mask chosen by the word address. This forces untouched clear-on-one bits to zero in the written word. A one-cycle debug pulse marks each case where the filter changed the word.

Top module: `cfg_merge_bridge`

## Requirements
- R1: Every register-file access is a 32-bit access whose address is the request offset with bits [1:0] forced to zero.
- R2: A request whose aligned address is greater than the parameter `SPACE_LAST` (default 0x1FC) makes no register-file access and still responds with `rsp_err` = 0. This check comes before any check of size or alignment.
- R3: A byte or halfword request reads the aligned word first. If that read returns `rf_err` = 1, the bridge responds with `rsp_err` = 1 and issues no write.
- R4: For a byte write (`req_size` = 2'b00), the lane shift is offset[1:0]×8 and the merge mask is 0xFF shifted left by that amount.
- R5: For a halfword write (`req_size` = 2'b01), the lane shift is offset[1]×16 and the merge mask is 0xFFFF shifted left by that amount.
- R6: The written word is (filtered_old AND NOT mask) OR ((`req_data` << shift) AND mask).
- R7: A halfword request with offset[0] = 1, or any request with `req_size` = 2'b11, is answered with `rsp_err` = 1 and makes no register-file access.
- R8: A word write (`req_size` = 2'b10) does no read and writes `req_data` unchanged, with no filtering.
- R9: Before the merge, the read-back word is ANDed with a keep mask chosen by word address: 0x01C keeps 0x00FFFFFF, 0x050 keeps 0xFFF0FFFF, 0x058 keeps 0x3FFFFFFF, and 0x078 keeps 0xF000FFFF.
- R10: At word addresses 0x104, 0x110, 0x130, 0x180, 0x184, 0x188 and 0x18C, the read-back word is replaced by zero before the merge.
- R11: At any other word address, the read-back word is merged unmodified.
- R12: `w1c_hit` is high for exactly one cycle, in the cycle after the read is acknowledged, when the filter changed the read-back word. It stays low otherwise.
- R13: `req_ready` is high only while the bridge is idle, so it is low from acceptance until the response. Each request gets one `rsp_valid` pulse of one cycle. `rsp_err` on that pulse equals `rf_err` of the write when a write was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle; request accepted when valid is high |
| req_offset | input | ADDR_W | Byte offset of the write |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_data | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Error status, valid with rsp_valid |
| rf_rd_en | output | 1 | Register-file read, held until acknowledged |
| rf_wr_en | output | 1 | Register-file write, held until acknowledged |
| rf_addr | output | ADDR_W | Word-aligned register address |
| rf_wdata | output | 32 | Write word |
| rf_rdata | input | 32 | Read word, valid with rf_ack |
| rf_ack | input | 1 | Access completes this cycle |
| rf_err | input | 1 | Access error, valid with rf_ack |
| w1c_hit | output | 1 | Pulse when the filter changed the read-back word |

## Verification
The hardest case to reach is the filter acting on a clear-on-one bit that is set outside the lanes being written. This needs a narrow write to one of the eleven filtered addresses while the register model holds ones in exactly the masked field. The bench preloads the model with all-ones and random words. It then aims directed byte and halfword writes at every lane of those addresses, and steers a share of the random requests onto them. Read errors are injected at random so that the abort path also meets filtered addresses.

// File: rtl/cfg_merge_pkg.sv
package cfg_merge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } brg_state_e;

  localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/w1c_filter.sv
// Per-address keep mask: bits cleared here are clear-on-one status bits.
module w1c_filter #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [31:0]       keep_mask
);

  always_comb begin
    keep_mask = 32'hFFFF_FFFF;
    case (word_addr)
      ADDR_W'(12'h01C): keep_mask = 32'h00FF_FFFF;
      ADDR_W'(12'h050): keep_mask = 32'hFFF0_FFFF;
      ADDR_W'(12'h058): keep_mask = 32'h3FFF_FFFF;
      ADDR_W'(12'h078): keep_mask = 32'hF000_FFFF;
      ADDR_W'(12'h104),
      ADDR_W'(12'h110),
      ADDR_W'(12'h130),
      ADDR_W'(12'h180),
      ADDR_W'(12'h184),
      ADDR_W'(12'h188),
      ADDR_W'(12'h18C): keep_mask = 32'h0000_0000;
      default:          keep_mask = 32'hFFFF_FFFF;
    endcase
  end

endmodule

// File: rtl/lane_merge.sv
// Filters the old word and inserts the new lanes.
module lane_merge
  import cfg_merge_pkg::*;
(
  input  xfer_size_e  size,
  input  logic [1:0]  lane,
  input  logic [31:0] old_word,
  input  logic [31:0] keep_mask,
  input  logic [31:0] new_data,
  output logic [31:0] merged,
  output logic        filt_changed
);

  logic [4:0]  shamt;
  logic [31:0] lane_mask;
  logic [31:0] filtered;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        shamt     = {lane, 3'b000};
        lane_mask = 32'h0000_00FF << shamt;
      end
      SZ_HALF: begin
        shamt     = {lane[1], 4'b0000};
        lane_mask = 32'h0000_FFFF << shamt;
      end
      default: begin
        shamt     = 5'd0;
        lane_mask = 32'hFFFF_FFFF;
      end
    endcase
  end

  assign filtered     = old_word & keep_mask;
  assign filt_changed = (filtered != old_word);
  assign merged       = (filtered & ~lane_mask) | ((new_data << shamt) & lane_mask);

endmodule

// File: rtl/cfg_merge_bridge.sv
module cfg_merge_bridge
  import cfg_merge_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] SPACE_LAST = ADDR_W'(12'h1FC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rf_rd_en,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [31:0]       rf_wdata,
  input  logic [31:0]       rf_rdata,
  input  logic              rf_ack,
  input  logic              rf_err,
  output logic              w1c_hit
);

  brg_state_e        state_q, state_d;
  logic [ADDR_W-1:0] off_q, off_d;
  xfer_size_e        size_q, size_d;
  logic [31:0]       data_q, data_d;
  logic [31:0]       wdata_q, wdata_d;
  logic              err_q, err_d;
  logic              hit_q, hit_d;

  logic [ADDR_W-1:0] in_aligned;
  logic [ADDR_W-1:0] held_aligned;
  logic              out_of_range;
  logic              bad_shape;
  logic              accept;
  xfer_size_e        in_size;
  logic [31:0]       keep_mask;
  logic [31:0]       merged;
  logic              filt_changed;

  assign in_size      = xfer_size_e'(req_size);
  assign in_aligned   = {req_offset[ADDR_W-1:2], 2'b00};
  assign held_aligned = {off_q[ADDR_W-1:2], 2'b00};
  assign out_of_range = (in_aligned > SPACE_LAST);
  assign bad_shape    = (in_size == SZ_BAD) || ((in_size == SZ_HALF) && req_offset[0]);
  assign accept       = (state_q == ST_IDLE) && req_valid;

  w1c_filter #(.ADDR_W(ADDR_W)) u_filter (
    .word_addr (held_aligned),
    .keep_mask (keep_mask)
  );

  lane_merge u_merge (
    .size         (size_q),
    .lane         (off_q[1:0]),
    .old_word     (rf_rdata),
    .keep_mask    (keep_mask),
    .new_data     (data_q),
    .merged       (merged),
    .filt_changed (filt_changed)
  );

  // Next-state and datapath enables
  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    size_d  = size_q;
    data_d  = data_q;
    wdata_d = wdata_q;
    err_d   = err_q;
    hit_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          off_d  = req_offset;
          size_d = in_size;
          data_d = req_data;
          if (out_of_range) begin
            err_d   = 1'b0;
            state_d = ST_RESP;
          end else if (bad_shape) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else if (in_size == SZ_WORD) begin
            wdata_d = req_data;
            state_d = ST_WRITE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (rf_ack) begin
          if (rf_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else begin
            wdata_d = merged;
            hit_d   = filt_changed;
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (rf_ack) begin
          err_d   = rf_err;
          state_d = ST_RESP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      data_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      size_q  <= size_d;
      data_q  <= data_d;
      wdata_q <= wdata_d;
      err_q   <= err_d;
      hit_q   <= hit_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rf_rd_en  = (state_q == ST_READ);
  assign rf_wr_en  = (state_q == ST_WRITE);
  assign rf_addr   = held_aligned;
  assign rf_wdata  = wdata_q;
  assign w1c_hit   = hit_q;

endmodule

// File: rtl/cfg_merge_bridge_chk.sv
module cfg_merge_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic rf_rd_en,
  input logic rf_wr_en,
  input logic rf_ack,
  input logic rf_err,
  input logic w1c_hit
);

  // R13: no register access while the request port is open
  p_busy_not_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_en || rf_wr_en) |-> !req_ready);

  // R13: response is a single-cycle pulse
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R13: write status is returned on the response
  p_wr_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && rf_ack) |=> (rsp_valid && (rsp_err == $past(rf_err))));

  // R3: failed read aborts without a write
  p_rd_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_en && rf_ack && rf_err) |=> (!rf_wr_en && rsp_valid && rsp_err));

  // R3: successful read is followed by the write
  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_en && rf_ack && !rf_err) |=> rf_wr_en);

  // R12: filter pulse only right after a good read
  p_hit_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_hit |-> ($past(rf_rd_en && rf_ack && !rf_err) && rf_wr_en));

  // R12: pulse lasts one cycle
  p_hit_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_hit |=> !w1c_hit);

endmodule

bind cfg_merge_bridge cfg_merge_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rf_rd_en  (rf_rd_en),
  .rf_wr_en  (rf_wr_en),
  .rf_ack    (rf_ack),
  .rf_err    (rf_err),
  .w1c_hit   (w1c_hit)
);

// File: tb/sim_cfg_merge_bridge.sv
`timescale 1ns/1ps
module sim_cfg_merge_bridge;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_offset = '0;
  logic [1:0]    req_size = 2'b00;
  logic [31:0]   req_data = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic          rf_rd_en;
  logic          rf_wr_en;
  logic [AW-1:0] rf_addr;
  logic [31:0]   rf_wdata;
  logic [31:0]   rf_rdata = '0;
  logic          rf_ack = 1'b0;
  logic          rf_err = 1'b0;
  logic          w1c_hit;

  always #5 clk = ~clk;

  cfg_merge_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_size(req_size), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rf_rd_en(rf_rd_en),
    .rf_wr_en(rf_wr_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .rf_ack(rf_ack), .rf_err(rf_err), .w1c_hit(w1c_hit)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Register file model
  logic [31:0] mem [0:127];
  int          n_rd = 0, n_wr = 0, n_hit = 0;
  logic [AW-1:0] last_addr = '0;
  logic [AW-1:0] last_rd_addr = '0;
  logic [31:0] last_data = '0;
  int          lat = 0;
  logic        inj_err = 1'b0;

  always @(negedge clk) begin
    if (w1c_hit) n_hit++;
    if (rf_ack) begin
      rf_ack = 1'b0;
      rf_err = 1'b0;
    end else if (rf_rd_en || rf_wr_en) begin
      if (lat == 0) begin
        rf_ack = 1'b1;
        if (rf_rd_en) begin
          rf_rdata     = mem[rf_addr[8:2]];
          rf_err       = inj_err;
          last_rd_addr = rf_addr;
          n_rd++;
        end else begin
          mem[rf_addr[8:2]] = rf_wdata;
          last_addr = rf_addr;
          last_data = rf_wdata;
          rf_err    = 1'b0;
          n_wr++;
        end
        lat = int'($urandom % 3);
      end else begin
        lat--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input logic [AW-1:0] a);
    case (a)
      12'h01C: return 32'h00FF_FFFF;
      12'h050: return 32'hFFF0_FFFF;
      12'h058: return 32'h3FFF_FFFF;
      12'h078: return 32'hF000_FFFF;
      12'h104, 12'h110, 12'h130, 12'h180,
      12'h184, 12'h188, 12'h18C: return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic run_req(input logic [AW-1:0] off, input logic [1:0] sz,
                         input logic [31:0] d, input logic rd_err);
    logic [AW-1:0] wa;
    logic [31:0] old, filt, m, exp_w;
    int sh;
    int rd0, wr0, hit0;
    bit oor, bad, exp_err, got_err;
    int exp_rd, exp_wr, exp_hit;
    wa   = {off[AW-1:2], 2'b00};
    old  = mem[wa[8:2]];
    oor  = (wa > 12'h1FC);
    bad  = (sz == 2'b11) || (sz == 2'b01 && off[0]);
    filt = old & keep_of(wa);
    if (sz == 2'b00) begin sh = 8 * int'(off[1:0]); m = 32'hFF << sh; end
    else if (sz == 2'b01) begin sh = 16 * int'(off[1]); m = 32'hFFFF << sh; end
    else begin sh = 0; m = 32'hFFFF_FFFF; end
    exp_w = (sz == 2'b10) ? d : ((filt & ~m) | ((d << sh) & m));
    exp_rd = 0; exp_wr = 0; exp_hit = 0; exp_err = 0;
    if (oor) begin
    end else if (bad) begin
      exp_err = 1;
    end else if (sz == 2'b10) begin
      exp_wr = 1;
    end else begin
      exp_rd = 1;
      if (rd_err) exp_err = 1;
      else begin
        exp_wr = 1;
        exp_hit = (filt != old) ? 1 : 0;
      end
    end
    inj_err = rd_err;
    rd0 = n_rd; wr0 = n_wr; hit0 = n_hit;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_offset = off; req_size = sz; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 ready low after accept", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    got_err = rsp_err;
    @(negedge clk);
    chk("R13 response one cycle", {31'd0, rsp_valid}, 32'd0);
    chk("R3/R7 response status", {31'd0, got_err}, {31'd0, exp_err});
    chk("R2/R3/R8 read count", n_rd - rd0, exp_rd);
    chk("R2/R3/R7 write count", n_wr - wr0, exp_wr);
    chk("R12 filter pulse count", n_hit - hit0, exp_hit);
    if (exp_rd == 1) chk("R1 read address", {20'd0, last_rd_addr}, {20'd0, wa});
    if (exp_wr == 1) begin
      chk("R1 write address", {20'd0, last_addr}, {20'd0, wa});
      chk("R4/R5/R6/R8/R9/R10/R11 write word", last_data, exp_w);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R13 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R13 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R3 reset no access", {30'd0, rf_rd_en, rf_wr_en}, 32'd0);
    chk("R12 reset hit", {31'd0, w1c_hit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 partial masks, byte and halfword lanes, all-ones background
    run_req(12'h01C, 2'b00, 32'h5A, 0);
    run_req(12'h01F, 2'b00, 32'hA5, 0);
    run_req(12'h052, 2'b01, 32'h1234, 0);
    run_req(12'h058, 2'b00, 32'h00, 0);
    run_req(12'h07B, 2'b00, 32'h3C, 0);
    // R10 full masks
    mem[12'h104 >> 2] = 32'hFFFF_FFFF;
    run_req(12'h105, 2'b00, 32'h81, 0);
    mem[12'h18C >> 2] = 32'hDEAD_BEEF;
    run_req(12'h18E, 2'b01, 32'hCAFE, 0);
    // R11 unfiltered address
    run_req(12'h020, 2'b00, 32'h00, 0);
    // R8 word write at filtered address, no read
    run_req(12'h050, 2'b10, 32'hFFFF_FFFF, 0);
    // R7 misaligned halfword and invalid size
    run_req(12'h051, 2'b01, 32'h1111, 0);
    run_req(12'h040, 2'b11, 32'h2222, 0);
    // R2 boundary: last word in range, first out of range, out of range with bad size
    run_req(12'h1FF, 2'b00, 32'h77, 0);
    run_req(12'h200, 2'b00, 32'h77, 0);
    run_req(12'hFFD, 2'b01, 32'h77, 0);
    // R3 read error at filtered address
    run_req(12'h110, 2'b00, 32'h99, 1);

    for (int i = 0; i < 128; i++) mem[i] = $urandom;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] off;
      logic [AW-1:0] picks [11];
      picks = '{12'h01C, 12'h050, 12'h058, 12'h078, 12'h104, 12'h110,
                12'h130, 12'h180, 12'h184, 12'h188, 12'h18C};
      if ($urandom % 2 == 0) off = picks[$urandom % 11] | AW'($urandom % 4);
      else off = AW'($urandom % 12'h220);
      if ($urandom % 4 == 0) mem[off[8:2]] = 32'hFFFF_FFFF;
      run_req(off, 2'($urandom % 4), $urandom, ($urandom % 8) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R13: actual hung expected response");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule